// File: doc/BRIEF.md
# Per-Channel Amplitude Serializer

This block is the digital back end of one direct-timing channel. The analog front end raises a peak-found strobe, and an external converter supplies a 6-bit amplitude code a short, programmable time later. The block answers the strobe with a one-cycle timing mark on a single output wire, so that the leading edge carries the peak time. It then waits out the conversion interval, captures the code and shifts it out most significant bit first, one bit per cycle of the dedicated 160 MHz channel clock. After that it spends a short reset phase and re-arms.

The conversion interval is counted from the edge that accepts the strobe. The mark cycle is the first cycle of that interval. With this choice the longest event, including the reset phase, stays within the dead-time budget of 16 clock cycles (100 ns). The delay setting is captured when the event starts. A strobe that comes while the channel is busy is dropped and leaves a sticky flag that only reset clears.

Top module: `amp_ser_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `ser_o` is 0, `ready_o` is 1 and `ovf_o` is 0.
- R2: While the channel is idle, `ready_o` is 1 and `ser_o` is 0.
- R3: A clock edge that samples `peak_i` high while `ready_o` is 1 starts an event. In the cycle after that edge (cycle 1), `ser_o` is 1 and `ready_o` is 0, and `ser_o` is 1 for that single cycle only.
- R4: With `cfg_dly_i` = c sampled at the starting edge, the conversion interval is D = c + 1 cycles (1 to 8). `ser_o` is 0 in cycles 2 to D.
- R5: In cycles D+1 to D+6, `ser_o` carries code bit 5, then bit 4, and so on down to bit 0, one bit per cycle.
- R6: The code is captured only at the edge that ends cycle D. Values of `code_i` in other cycles, and changes of `cfg_dly_i` after the starting edge, do not affect the output.
- R7: After bit 0 comes a reset phase of RST_CYCLES cycles (1 by default) with `ser_o` 0 and `ready_o` 0. `ready_o` returns to 1 in cycle D+7+RST_CYCLES. The longest event therefore keeps `ready_o` low for 15 cycles, fewer than 16.
- R8: A `peak_i` sampled high while `ready_o` is 0 is ignored: the running event's output is unchanged. It sets `ovf_o`, which stays 1 until reset.
- R9: A `peak_i` that is high in the first cycle with `ready_o` back at 1 starts the next event at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dedicated channel clock (160 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| peak_i | input | 1 | Peak-found strobe from the front end |
| cfg_dly_i | input | DLY_W (3) | Conversion delay setting, D = value + 1 cycles |
| code_i | input | DW (6) | Amplitude code from the external converter |
| ser_o | output | 1 | Serial line: timing mark, then data bits |
| ready_o | output | 1 | Channel armed for the next event |
| ovf_o | output | 1 | Sticky flag: a strobe was dropped while busy |

## Verification
The bench checks the shortest and the longest conversion setting. A design that counted the interval from the end of the mark, or that was off by one in the gap counter, would move every data bit by a cycle or break the 16-cycle dead-time budget. The converter code is valid only during cycle D and is inverted in every other cycle, so a design that sampled it at the peak or one edge late would send the inverted bits. The delay setting is also flipped in the middle of an event, which catches a design that does not hold it. Events are run back to back, and a strobe is injected in the middle of an event. A design that fails to re-arm at once would delay the second mark. One that restarts on the injected strobe, or forgets to keep the overflow flag, would show a corrupted bit stream or a flag that is 0 at the end.

// File: rtl/amp_ser_pkg.sv
package amp_ser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MARK,
    ST_GAP,
    ST_SHIFT,
    ST_RST
  } seq_state_t;
endpackage

// File: rtl/amp_ser_ctrl.sv
module amp_ser_ctrl
  import amp_ser_pkg::*;
#(
  parameter int DW         = 6,
  parameter int DLY_W      = 3,
  parameter int RST_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             peak_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             mark_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             ready_o,
  output logic             ovf_o
);
  localparam int BC_W = $clog2(DW);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  seq_state_t       state;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] gcnt;
  logic [BC_W-1:0]  bcnt;
  logic [RC_W-1:0]  rcnt;
  logic             last_bit;

  // Commands for the shifter, decoded from the current state
  always_comb begin
    last_bit = (bcnt == BC_W'(DW - 1));
    mark_o   = (state == ST_IDLE) && peak_i;
    load_o   = ((state == ST_MARK) && (dly_q == '0)) ||
               ((state == ST_GAP) && (gcnt == DLY_W'(1)));
    shift_o  = (state == ST_SHIFT) && !last_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ready_o <= 1'b1;
      ovf_o   <= 1'b0;
      dly_q   <= '0;
      gcnt    <= '0;
      bcnt    <= '0;
      rcnt    <= '0;
    end else begin
      if (peak_i && (state != ST_IDLE)) ovf_o <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (peak_i) begin
            state   <= ST_MARK;
            dly_q   <= dly_i;
            ready_o <= 1'b0;
          end
        end
        ST_MARK: begin
          if (load_o) begin
            state <= ST_SHIFT;
            bcnt  <= '0;
          end else begin
            state <= ST_GAP;
            gcnt  <= dly_q;
          end
        end
        ST_GAP: begin
          if (gcnt == DLY_W'(1)) begin
            state <= ST_SHIFT;
            bcnt  <= '0;
          end else begin
            gcnt <= gcnt - DLY_W'(1);
          end
        end
        ST_SHIFT: begin
          if (last_bit) begin
            state <= ST_RST;
            rcnt  <= RC_W'(RST_CYCLES - 1);
          end else begin
            bcnt <= bcnt + BC_W'(1);
          end
        end
        ST_RST: begin
          if (rcnt == '0) begin
            state   <= ST_IDLE;
            ready_o <= 1'b1;
          end else begin
            rcnt <= rcnt - RC_W'(1);
          end
        end
        default: begin
          state   <= ST_IDLE;
          ready_o <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/amp_ser_shift.sv
module amp_ser_shift #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mark_i,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [DW-1:0] code_i,
  output logic          ser_o
);
  logic [DW-2:0] rest_q;

  // Registered serial line: mark has priority, then load, then shift
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_o  <= 1'b0;
      rest_q <= '0;
    end else if (mark_i) begin
      ser_o <= 1'b1;
    end else if (load_i) begin
      {ser_o, rest_q} <= code_i;
    end else if (shift_i) begin
      {ser_o, rest_q} <= {rest_q, 1'b0};
    end else begin
      ser_o <= 1'b0;
    end
  end
endmodule

// File: rtl/amp_ser_top.sv
module amp_ser_top #(
  parameter int DW         = 6,
  parameter int DLY_W      = 3,
  parameter int RST_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             peak_i,
  input  logic [DLY_W-1:0] cfg_dly_i,
  input  logic [DW-1:0]    code_i,
  output logic             ser_o,
  output logic             ready_o,
  output logic             ovf_o
);
  logic mark_w;
  logic load_w;
  logic shift_w;

  amp_ser_ctrl #(
    .DW(DW), .DLY_W(DLY_W), .RST_CYCLES(RST_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .peak_i(peak_i), .dly_i(cfg_dly_i),
    .mark_o(mark_w), .load_o(load_w), .shift_o(shift_w),
    .ready_o(ready_o), .ovf_o(ovf_o)
  );

  amp_ser_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .mark_i(mark_w), .load_i(load_w),
    .shift_i(shift_w), .code_i(code_i), .ser_o(ser_o)
  );
endmodule

// File: rtl/amp_ser_chk.sv
module amp_ser_chk #(
  parameter int DW         = 6,
  parameter int DLY_W      = 3,
  parameter int RST_CYCLES = 1
) (
  input logic clk,
  input logic rst,
  input logic peak_i,
  input logic ser_o,
  input logic ready_o,
  input logic ovf_o
);
  localparam int DEAD_MAX = (1 << DLY_W) + DW + RST_CYCLES;
  localparam int BW       = $clog2(DEAD_MAX + 2);

  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || ready_o) busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + BW'(1);
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (ready_o && !ser_o && !ovf_o));

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !ser_o);

  assert_mark_start_R3: assert property (@(posedge clk) disable iff (rst)
    (ready_o && peak_i) |=> (ser_o && !ready_o));

  assert_dead_time_R7: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (busy_cnt < BW'(DEAD_MAX)));

  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && peak_i) |=> ovf_o);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
endmodule

bind amp_ser_top amp_ser_chk #(
  .DW(DW), .DLY_W(DLY_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .peak_i(peak_i),
  .ser_o(ser_o), .ready_o(ready_o), .ovf_o(ovf_o)
);

// File: tb/amp_ser_top_bench.sv
module amp_ser_top_bench;
  localparam int DW    = 6;
  localparam int DLY_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             peak_i = 1'b0;
  logic [DLY_W-1:0] cfg_dly_i = '0;
  logic [DW-1:0]    code_i = '0;
  logic             ser_o;
  logic             ready_o;
  logic             ovf_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  amp_ser_top u_amp_ser_top (
    .clk(clk), .rst(rst), .peak_i(peak_i), .cfg_dly_i(cfg_dly_i),
    .code_i(code_i), .ser_o(ser_o), .ready_o(ready_o), .ovf_o(ovf_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // One event; inject_at > 0 pulses peak_i in that busy cycle
  task automatic run_event(input logic [DW-1:0] code, input int cfg, input int inject_at);
    int d;
    logic exp_ser;
    d = cfg + 1;
    peak_i    = 1'b1;
    cfg_dly_i = DLY_W'(cfg);
    code_i    = ~code;
    for (int k = 1; k <= d + 8; k++) begin
      step();
      if (k == 1) begin
        check("R3 mark", ser_o, 1'b1);
        check("R3 ready low", ready_o, 1'b0);
      end else if (k <= d) begin
        check("R4 gap", ser_o, 1'b0);
      end else if (k <= d + 6) begin
        exp_ser = code[DW - 1 - (k - d - 1)];
        check("R5 R6 data bit", ser_o, exp_ser);
      end else if (k == d + 7) begin
        check("R7 reset phase ser", ser_o, 1'b0);
        check("R7 reset phase ready", ready_o, 1'b0);
      end else begin
        check("R7 ready back", ready_o, 1'b1);
        check("R2 idle low", ser_o, 1'b0);
      end
      if (k < d + 7) check("R7 busy", ready_o, 1'b0);
      peak_i    = (k == inject_at);
      cfg_dly_i = ~DLY_W'(cfg);
      code_i    = (k == d) ? code : ~code;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    check("R1 ser", ser_o, 1'b0);
    check("R1 ready", ready_o, 1'b1);
    check("R1 ovf", ovf_o, 1'b0);
    rst = 1'b0;
    step();
    check("R1 ready after release", ready_o, 1'b1);
    check("R1 ovf after release", ovf_o, 1'b0);
    code_i = 6'b111111;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R2 idle ser", ser_o, 1'b0);
      check("R2 idle ready", ready_o, 1'b1);
    end
  endtask

  task automatic t_basic();
    run_event(6'b101101, 3, 0);
    check("R8 no overflow yet", ovf_o, 1'b0);
  endtask

  task automatic t_min_delay();
    run_event(6'b100001, 0, 0);
  endtask

  task automatic t_max_delay();
    run_event(6'b010110, 7, 0);
  endtask

  task automatic t_back_to_back();
    run_event(6'b110010, 1, 0);
    run_event(6'b001101, 5, 0);
    check("R9 no overflow on rearm", ovf_o, 1'b0);
  endtask

  task automatic t_overflow();
    run_event(6'b011011, 4, 3);
    check("R8 overflow set", ovf_o, 1'b1);
    run_event(6'b111000, 2, 0);
    check("R8 overflow sticky", ovf_o, 1'b1);
    peak_i = 1'b0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    check("R1 overflow cleared", ovf_o, 1'b0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_min_delay();
    t_max_delay();
    t_back_to_back();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule